// File: doc/BRIEF.md
# Clock Frequency Meter

This unit measures the rate of one clock out of a bank of internal clocks. It counts the selected clock's rising edges during a window whose length is a number of reference-clock cycles. Software first chooses a source in the control register, then loads a window length into the window register, polls until the busy flag drops, and finally reads the edge count. With a 19.2 MHz reference and a load of 19200, the window is one millisecond and the count is the measured rate in kHz.

The source index is 6 bits wide and lives in two separate fields of the control register. Index 0 selects nothing. A kill command in the control register aborts a measurement in progress. The edge counter runs in the measured clock's own domain. The window gate is synchronized into that domain. The frozen count comes back through a toggle handshake, and busy clears only after the count has been captured in the reference domain.

The register port is a plain single-cycle write strobe with a combinational read. It has no back-pressure: every write is taken on the clock edge where `reg_wr` is high. No data stream leaves the block, so it has no valid/ready interface.

Top module: `clk_freq_meter`

## Requirements
- R1: Register addresses are control = 0, result = 1 and window = 2. After reset all three read as zero.
- R2: Control bits [3:0] hold source index bits [3:0], and control bits [13:12] hold index bits [5:4]. These fields read back as written. Index i (1..NUM_SRC) selects `src_clk[i-1]`, and index 0 selects no clock.
- R3: Writing the window register loads it. While the value is nonzero it falls by one on every `clk` cycle. It reads back its live value and reads zero once the window has elapsed.
- R4: Busy (control bit 7) is set by a nonzero window write. It stays set while the window runs and after the window reaches zero, until the result has been captured.
- R5: When busy clears, the result equals the number of selected-clock rising edges within the window, which is W·Tclk/Tsrc to within ±2.
- R6: A window write while a window is running restarts the window with the new value and clears the edge count.
- R7: The edge count saturates at 2^CNT_W−1 and does not wrap.
- R8: A control write with bit 5 set (kill) clears busy, the window and the source index at once. The result is left unchanged.
- R9: The result register changes only when a measurement completes. Writing zero to the control register deselects the source and leaves the result unchanged.
- R10: With index 0 selected, no edges arrive, so busy stays set after the window expires until a kill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; register port and window counter |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| src_clk | input | NUM_SRC | Candidate clocks; bit i-1 is source index i |

## Verification
Assertions check on every cycle that:
- busy covers any nonzero window;
- the window falls by exactly one per cycle when no write occurs;
- a kill lands the unit in idle;
- the result holds while idle;
- the edge count never wraps and stays frozen outside the window.

Only the bench scenarios can show that the counts are accurate, because that depends on the true periods of asynchronous clocks. The bench sweeps every source index, which also proves that the split index fields are decoded correctly. Restart, saturation, kill and the no-source hang are likewise shown by the bench scenarios.

// File: rtl/clk_freq_meter_pkg.sv
package clk_freq_meter_pkg;
  localparam int REG_AW     = 2;
  localparam logic [REG_AW-1:0] A_CTRL   = 2'd0;
  localparam logic [REG_AW-1:0] A_RESULT = 2'd1;
  localparam logic [REG_AW-1:0] A_WINDOW = 2'd2;

  localparam int SEL_W      = 6;
  localparam int SEL_LO_W   = 4;
  localparam int SEL_HI_W   = SEL_W - SEL_LO_W;
  localparam int SEL_HI_LSB = 12;
  localparam int KILL_BIT   = 5;
  localparam int BUSY_BIT   = 7;

  function automatic logic [SEL_W-1:0] ctrl_to_sel(input logic [31:0] w);
    return {w[SEL_HI_LSB +: SEL_HI_W], w[SEL_LO_W-1:0]};
  endfunction

  function automatic logic [31:0] sel_to_ctrl(input logic [SEL_W-1:0] sel, input logic busy);
    logic [31:0] r;
    r = '0;
    r[SEL_LO_W-1:0]              = sel[SEL_LO_W-1:0];
    r[SEL_HI_LSB +: SEL_HI_W]    = sel[SEL_W-1:SEL_LO_W];
    r[BUSY_BIT]                  = busy;
    return r;
  endfunction
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/fm_src_mux.sv
module fm_src_mux #(
  parameter int NUM_SRC = 40,
  parameter int SEL_W   = 6
) (
  input  logic [NUM_SRC-1:0] src_clk,
  input  logic [SEL_W-1:0]   sel,
  output logic               clk_out
);
  logic [NUM_SRC-1:0] hit;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_term
    assign hit[i] = src_clk[i] & (sel == SEL_W'(i + 1));
  end

  assign clk_out = |hit;
endmodule

// File: rtl/fm_edge_counter.sv
module fm_edge_counter #(
  parameter int CNT_W = 32
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             gate_async,
  input  logic             start_tog_async,
  output logic [CNT_W-1:0] count,
  output logic             done_tog
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic gate_s, start_s, gate_d, start_d, clear;

  fm_sync #(.STAGES(2)) u_gate_sync (
    .clk(mclk), .rst_n(rst_n), .d(gate_async), .q(gate_s));
  fm_sync #(.STAGES(2)) u_start_sync (
    .clk(mclk), .rst_n(rst_n), .d(start_tog_async), .q(start_s));

  // a new window (restart toggle or gate rise) clears the count
  assign clear = (start_s != start_d) || (gate_s && !gate_d);

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      gate_d   <= 1'b0;
      start_d  <= 1'b0;
      done_tog <= 1'b0;
    end else begin
      gate_d  <= gate_s;
      start_d <= start_s;
      if (clear)                           count <= '0;
      else if (gate_s && count != CNT_MAX) count <= count + 1'b1;
      if (gate_d && !gate_s)               done_tog <= ~done_tog;
    end
  end

  AST_CNT_SATURATES: assert property (@(posedge mclk) disable iff (!rst_n)
    (count == CNT_MAX && start_s == start_d) |=> count == CNT_MAX); // R7
  AST_CNT_FROZEN_OUTSIDE: assert property (@(posedge mclk) disable iff (!rst_n)
    (!gate_s && start_s == start_d) |=> $stable(count)); // R5
endmodule

// File: rtl/fm_window_ctl.sv
module fm_window_ctl
  import clk_freq_meter_pkg::*;
#(
  parameter int WIN_W = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_win,
  input  logic [31:0]      wdata,
  input  logic [CNT_W-1:0] meas_count,
  input  logic             done_tog_async,
  output logic [SEL_W-1:0] sel,
  output logic             busy,
  output logic [WIN_W-1:0] win_cnt,
  output logic [CNT_W-1:0] result,
  output logic             start_tog,
  output logic             gate
);
  logic kill, done_s, done_seen, take, start_now;
  logic unused_wdata;

  assign unused_wdata = ^wdata;
  assign kill      = wr_ctrl && wdata[KILL_BIT];
  assign start_now = wr_win && (wdata[WIN_W-1:0] != '0);
  // result only accepted once the window is over; stale toggles are absorbed
  assign take      = busy && (win_cnt == '0) && (done_s != done_seen);
  assign gate      = (win_cnt != '0);

  fm_sync #(.STAGES(2)) u_done_sync (
    .clk(clk), .rst_n(rst_n), .d(done_tog_async), .q(done_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel       <= '0;
      busy      <= 1'b0;
      win_cnt   <= '0;
      result    <= '0;
      start_tog <= 1'b0;
      done_seen <= 1'b0;
    end else begin
      done_seen <= done_s;
      if (kill) begin
        sel     <= '0;
        busy    <= 1'b0;
        win_cnt <= '0;
      end else begin
        if (wr_ctrl) sel <= ctrl_to_sel(wdata);
        if (take) begin
          busy   <= 1'b0;
          result <= meas_count;
        end
        if (wr_win) begin
          win_cnt <= wdata[WIN_W-1:0];
          if (start_now) begin
            busy      <= 1'b1;
            start_tog <= ~start_tog;
          end
        end else if (win_cnt != '0) begin
          win_cnt <= win_cnt - 1'b1;
        end
      end
    end
  end

  AST_BUSY_COVERS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt != '0) |-> busy); // R4
  AST_WIN_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_win && !kill && win_cnt != '0) |=> win_cnt == $past(win_cnt) - 1'b1); // R3
  AST_KILL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!busy && win_cnt == '0 && sel == '0)); // R8
  AST_RESULT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result)); // R9
endmodule

// File: rtl/clk_freq_meter.sv
module clk_freq_meter
  import clk_freq_meter_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int CNT_W   = 32,
  parameter int WIN_W   = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_SRC-1:0] src_clk
);
  logic [SEL_W-1:0] sel;
  logic             busy, start_tog, gate, meas_clk, done_tog;
  logic [WIN_W-1:0] win_cnt;
  logic [CNT_W-1:0] result, meas_count;

  fm_window_ctl #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(reg_wr && reg_addr == A_CTRL),
    .wr_win(reg_wr && reg_addr == A_WINDOW),
    .wdata(reg_wdata), .meas_count(meas_count), .done_tog_async(done_tog),
    .sel(sel), .busy(busy), .win_cnt(win_cnt), .result(result),
    .start_tog(start_tog), .gate(gate));

  fm_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .src_clk(src_clk), .sel(sel), .clk_out(meas_clk));

  fm_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .mclk(meas_clk), .rst_n(rst_n), .gate_async(gate),
    .start_tog_async(start_tog), .count(meas_count), .done_tog(done_tog));

  always_comb begin
    case (reg_addr)
      A_CTRL:   reg_rdata = sel_to_ctrl(sel, busy);
      A_RESULT: reg_rdata = 32'(result);
      A_WINDOW: reg_rdata = 32'(win_cnt);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/tb_clk_freq_meter.sv
`timescale 1ns/1ps
module tb_clk_freq_meter;
  localparam int NSRC = 40;
  localparam logic [1:0] AC = 2'd0, AR = 2'd1, AW = 2'd2;
  localparam int KILL = 32'h20;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  wire  [NSRC-1:0] src;
  logic wr_m = 0, wr_s = 0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_m, rd_s;
  int n_vec = 0, n_bad = 0;

  function automatic real per(int i);
    return 3.0 + 0.7 * i;
  endfunction

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic c = 1'b0;
    initial forever #(per(g + 1) / 2.0) c = ~c;
    assign src[g] = c;
  end

  clk_freq_meter #(.NUM_SRC(NSRC), .CNT_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_m), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rd_m), .src_clk(src));
  clk_freq_meter #(.NUM_SRC(NSRC), .CNT_W(8)) dut_sat (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr_s), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rd_s), .src_clk(src));

  function automatic logic [31:0] enc(int idx);
    return 32'((idx & 15) | ((idx >> 4) << 12));
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(bit s, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (s) wr_s = 1'b1; else wr_m = 1'b1;
    @(negedge clk);
    wr_m = 1'b0; wr_s = 1'b0;
  endtask

  task automatic rd(bit s, logic [1:0] a, bit wait_edge, output logic [31:0] v);
    if (wait_edge) @(negedge clk);
    addr = a;
    #1;
    v = s ? rd_s : rd_m;
  endtask

  task automatic measure(bit s, int idx, int w, output logic [31:0] cnt, output bit ok);
    logic [31:0] v;
    ok = 1'b0;
    wr(s, AC, KILL);
    wr(s, AC, enc(idx));
    wr(s, AW, 32'(w));
    for (int i = 0; i < w + 200; i++) begin
      rd(s, AC, 1, v);
      if (!v[7]) begin ok = 1'b1; break; end
    end
    rd(s, AR, 1, cnt);
  endtask

  task automatic chk_rate(logic [31:0] got, int idx, int w, string req);
    real e, d;
    e = w * 10.0 / per(idx);
    d = real'(got) - e;
    chk(d <= 2.0 && d >= -2.0, req, longint'(got), longint'(e));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, cnt, keep;
    bit ok;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(0, AC, 1, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(0, AR, 1, v); chk(v == 0, "R1 result", v, 0);
    rd(0, AW, 1, v); chk(v == 0, "R1 window", v, 0);

    // R2 split index field readback (index 43)
    wr(0, AC, enc(43));
    rd(0, AC, 1, v); chk(v == 32'h200B, "R2 ctrl readback", v, 32'h200B);

    // R3 live window readback, R4 busy beyond window end
    wr(0, AC, enc(7));
    wr(0, AW, 200);
    rd(0, AW, 1, v); chk(v == 199, "R3 window live", v, 199);
    repeat (8) @(negedge clk);
    rd(0, AW, 1, v); chk(v == 190, "R3 window live", v, 190);
    rd(0, AC, 0, v); chk(v[7] == 1, "R4 busy in window", v[7], 1);
    for (int i = 0; i < 300; i++) begin
      rd(0, AW, 1, v);
      if (v == 0) break;
    end
    chk(v == 0, "R3 window elapsed", v, 0);
    rd(0, AC, 0, v); chk(v[7] == 1, "R4 busy after window", v[7], 1);
    for (int i = 0; i < 100; i++) begin
      rd(0, AC, 1, v);
      if (!v[7]) break;
    end
    chk(v[7] == 0, "R4 busy clears", v[7], 0);
    rd(0, AR, 1, cnt); chk_rate(cnt, 7, 200, "R5 first");

    // R5 / R2 sweep of every source index
    for (int idx = 1; idx <= NSRC; idx++) begin
      measure(0, idx, 200, cnt, ok);
      chk(ok, "R4 busy completes", ok, 1);
      chk_rate(cnt, idx, 200, "R5 R2 sweep");
    end

    // R6 restart mid-window
    wr(0, AC, KILL);
    wr(0, AC, enc(10));
    wr(0, AW, 400);
    repeat (100) @(negedge clk);
    wr(0, AW, 200);
    for (int i = 0; i < 400; i++) begin
      rd(0, AC, 1, v);
      if (!v[7]) break;
    end
    rd(0, AR, 1, cnt); chk_rate(cnt, 10, 200, "R6 restart");

    // R7 saturation on narrow counter, plus a non-saturating case
    measure(1, 1, 200, cnt, ok); chk(cnt == 255, "R7 saturate", cnt, 255);
    measure(1, 40, 200, cnt, ok); chk_rate(cnt, 40, 200, "R7 narrow in range");

    // R8 kill mid-window
    measure(0, 12, 150, keep, ok);
    wr(0, AC, enc(5));
    wr(0, AW, 300);
    repeat (20) @(negedge clk);
    wr(0, AC, KILL);
    rd(0, AC, 0, v); chk(v == 0, "R8 kill ctrl idle", v, 0);
    rd(0, AW, 0, v); chk(v == 0, "R8 kill window", v, 0);
    repeat (50) @(negedge clk);
    rd(0, AR, 0, v); chk(v == keep, "R8 kill keeps result", v, keep);

    // R9 write zero deselects, result kept
    measure(0, 20, 150, keep, ok);
    wr(0, AC, 0);
    rd(0, AC, 0, v); chk(v == 0, "R9 ctrl zero", v, 0);
    rd(0, AR, 0, v); chk(v == keep, "R9 result kept", v, keep);

    // R10 no source: busy stuck until kill
    wr(0, AW, 50);
    repeat (120) @(negedge clk);
    rd(0, AC, 0, v); chk(v[7] == 1, "R10 busy stuck", v[7], 1);
    rd(0, AR, 0, v); chk(v == keep, "R10 result kept", v, keep);
    wr(0, AC, KILL);
    rd(0, AC, 0, v); chk(v[7] == 0, "R10 kill releases", v[7], 0);

    // recovery after dead source
    measure(0, 25, 200, cnt, ok); chk_rate(cnt, 25, 200, "R5 after dead source");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule